// File: doc/BRIEF.md
# Partitioned Saturating Lane Adder

This block adds or subtracts two 64-bit operands as a set of independent lanes. A two-bit lane-size select splits the carry chain into eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. Carries and borrows never pass from one lane into the next. Each lane detects its own overflow. Detection follows either the two's-complement rules or the unsigned rules, as the signed select chooses.

In wrap mode every lane returns its result modulo two to the power of its width. In saturate mode, a lane that overflows returns the extreme value that lies nearest the true result. One overflow bit is reported per 8-bit slice, so the flag word keeps one layout in every lane size.

The datapath is combinational. An optional register stage, enabled by default, samples result and flags on the rising clock edge. A synchronous active-low reset clears both.

Top module: `psat_adder`

## Requirements
- R1: `lane_mode` 0 gives eight 8-bit lanes, 1 gives four 16-bit lanes, 2 gives two 32-bit lanes and 3 gives one 64-bit lane. Lane k occupies the bits starting at k times the lane width. No carry or borrow crosses a lane boundary.
- R2: With `sub_en` low, each lane of `result` equals the lane of `op_a` plus the lane of `op_b`, modulo 2^W, unless it saturates.
- R3: With `sub_en` high, each lane equals `op_a` plus the inverted `op_b` plus one, which is `op_a` minus `op_b`, modulo 2^W, unless it saturates.
- R4: Signed add overflows only when both lane operands have the same sign bit and the result's sign bit differs from it.
- R5: A signed add of two lane operands whose sign bits differ never raises the lane's flag.
- R6: Signed subtract overflows only when the operand sign bits differ and the result's sign bit differs from the sign bit of `op_a`.
- R7: Unsigned add overflows on a carry out of the lane's top bit. Unsigned subtract overflows when the lane of `op_b` is greater than the lane of `op_a`.
- R8: Bit j of `ovf_flags` belongs to bits 8j+7..8j. A lane's flag sits on its most significant slice, and the flag bits of all other slices read 0.
- R9: With `sat_en` high and `signed_en` high, an overflowing lane whose `op_a` is non-negative returns the lane maximum, 0 followed by ones. A lane whose `op_a` is negative returns the lane minimum, 1 followed by zeros.
- R10: With `sat_en` high and `signed_en` low, an overflowing add lane returns all ones, and an overflowing subtract lane returns zero.
- R11: With `sat_en` low, an overflowing lane returns the wrapped result and still raises its flag.
- R12: With `OUT_REG`=1, `result` and `ovf_flags` reflect the inputs present at the previous rising clock edge. A synchronous reset with `rst_n` low clears both to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand (subtrahend when subtracting) |
| lane_mode | input | 2 | Lane size: 0=8, 1=16, 2=32, 3=64 bits |
| sub_en | input | 1 | 1 = subtract, 0 = add |
| signed_en | input | 1 | 1 = two's-complement overflow rules, 0 = unsigned |
| sat_en | input | 1 | 1 = clamp overflowing lanes, 0 = wrap |
| result | output | 64 | Per-lane sum or difference |
| ovf_flags | output | 8 | Per-slice overflow flags |

## Verification
With the default output register, the result and flags for a given operand set are due one rising edge after the operands are applied. The bench drives each vector on a falling edge and compares both outputs on the next falling edge, half a period after the capturing edge. That comparison point also sits one full cycle after the inputs settle, so no comparison depends on the order of processes at the capturing edge. The reset check holds `rst_n` low across a rising edge after a nonzero vector, and then expects zeros on the following falling edge.

// File: rtl/psat_pkg.sv
// Package: shared lane-size encoding and helpers for the partitioned adder.
// Assumes slices of 8 bits; lane spans are powers of two slices.
package psat_pkg;
    localparam int SLICE_W = 8;

    typedef enum logic [1:0] {
        LANE_8  = 2'd0,
        LANE_16 = 2'd1,
        LANE_32 = 2'd2,
        LANE_64 = 2'd3
    } lane_mode_e;

    // Number of slices spanned by one lane in the given mode.
    function automatic int lane_span(input logic [1:0] mode);
        return 1 << int'(mode);
    endfunction
endpackage

// File: rtl/psat_slice.sv
// Module: one slice of the split carry chain.
// Adds a, b (already conditionally inverted) and carry-in. It also
// exposes the carry into the top bit, which signed overflow detection needs.
// Assumes W >= 2.
module psat_slice #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         c_msb
);
    logic [W-1:0] low;
    logic [1:0]   top;

    // Low bits first, then the top bit, so the internal carry is visible.
    always_comb begin
        low   = {1'b0, a[W-2:0]} + {1'b0, b[W-2:0]} + {{(W-1){1'b0}}, cin};
        c_msb = low[W-1];
        top   = {1'b0, a[W-1]} + {1'b0, b[W-1]} + {1'b0, c_msb};
        sum   = {top[0], low[W-2:0]};
        cout  = top[1];
    end
endmodule

// File: rtl/psat_ovf.sv
// Module: overflow decision for one slice.
// Only a slice that ends a lane may raise a flag. Signed overflow is the
// carry into the top bit differing from the carry out. An unsigned add
// overflows on carry out; an unsigned subtract overflows on a missing
// carry out (a borrow).
module psat_ovf (
    input  logic is_top,
    input  logic sgn,
    input  logic sub,
    input  logic cout,
    input  logic c_msb,
    output logic ovf
);
    // Select the rule for the current number format.
    always_comb begin
        if (sgn) ovf = is_top & (cout ^ c_msb);
        else     ovf = is_top & (sub ? ~cout : cout);
    end
endmodule

// File: rtl/psat_clamp.sv
// Module: per-slice result selection between wrapped and clamped values.
// lane_ovf and a_sign are the flag and op_a sign of the slice's own lane.
// The clamp pattern depends on whether this slice is the top of its lane.
module psat_clamp #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw,
    input  logic         lane_ovf,
    input  logic         sat,
    input  logic         sgn,
    input  logic         sub,
    input  logic         a_sign,
    input  logic         is_top,
    output logic [W-1:0] out
);
    logic [W-1:0] clamp_val;

    // Extreme value: signed max/min by op_a sign, unsigned all ones or zero.
    always_comb begin
        if (sgn) begin
            if (is_top) clamp_val = {a_sign, {(W-1){~a_sign}}};
            else        clamp_val = {W{~a_sign}};
        end else begin
            clamp_val = {W{~sub}};
        end
        out = (sat && lane_ovf) ? clamp_val : raw;
    end
endmodule

// File: rtl/psat_adder.sv
// Module: partitioned add/subtract unit with per-lane overflow and saturation.
// The carry chain is cut at slice boundaries chosen by lane_mode. Each cut
// receives sub_en as carry-in, completing the two's-complement negation of
// op_b. Assumes DATA_W is a multiple of SLICE_W. Lane sizes larger than
// DATA_W collapse to one full-width lane.
module psat_adder #(
    parameter int DATA_W  = 64,
    parameter int SLICE_W = psat_pkg::SLICE_W,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DATA_W-1:0]          op_a,
    input  logic [DATA_W-1:0]          op_b,
    input  logic [1:0]                 lane_mode,
    input  logic                       sub_en,
    input  logic                       signed_en,
    input  logic                       sat_en,
    output logic [DATA_W-1:0]          result,
    output logic [DATA_W/SLICE_W-1:0]  ovf_flags
);
    localparam int N_SLICE = DATA_W / SLICE_W;

    logic [DATA_W-1:0]  b_eff;
    logic [N_SLICE-1:0] is_top, is_start, cin, cout, c_msb, ovf;
    logic [N_SLICE-1:0] lane_ovf, lane_sign;
    logic [DATA_W-1:0]  raw_sum, res_c;

    assign b_eff = op_b ^ {DATA_W{sub_en}};

    // Lane geometry: where lanes start and end, and each slice's lane top.
    always_comb begin
        int span;
        span = psat_pkg::lane_span(lane_mode);
        if (span > N_SLICE) span = N_SLICE;
        for (int i = 0; i < N_SLICE; i++) begin
            int top_idx;
            is_start[i]  = ((i % span) == 0);
            is_top[i]    = ((i % span) == span - 1);
            top_idx      = i - (i % span) + span - 1;
            lane_ovf[i]  = ovf[top_idx];
            lane_sign[i] = op_a[top_idx*SLICE_W + SLICE_W - 1];
        end
    end

    // Carry-in: sub_en at a lane start, otherwise the lower slice's carry out.
    always_comb begin
        cin[0] = sub_en;
        for (int i = 1; i < N_SLICE; i++)
            cin[i] = is_start[i] ? sub_en : cout[i-1];
    end

    for (genvar g = 0; g < N_SLICE; g++) begin : g_slice
        psat_slice #(.W(SLICE_W)) u_slice (
            .a     (op_a[g*SLICE_W +: SLICE_W]),
            .b     (b_eff[g*SLICE_W +: SLICE_W]),
            .cin   (cin[g]),
            .sum   (raw_sum[g*SLICE_W +: SLICE_W]),
            .cout  (cout[g]),
            .c_msb (c_msb[g])
        );
        psat_ovf u_ovf (
            .is_top (is_top[g]),
            .sgn    (signed_en),
            .sub    (sub_en),
            .cout   (cout[g]),
            .c_msb  (c_msb[g]),
            .ovf    (ovf[g])
        );
        psat_clamp #(.W(SLICE_W)) u_clamp (
            .raw      (raw_sum[g*SLICE_W +: SLICE_W]),
            .lane_ovf (lane_ovf[g]),
            .sat      (sat_en),
            .sgn      (signed_en),
            .sub      (sub_en),
            .a_sign   (lane_sign[g]),
            .is_top   (is_top[g]),
            .out      (res_c[g*SLICE_W +: SLICE_W])
        );
    end

    if (OUT_REG) begin : g_oreg
        // Output stage: capture result and flags, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result    <= '0;
                ovf_flags <= '0;
            end else begin
                result    <= res_c;
                ovf_flags <= ovf;
            end
        end

        for (genvar s = 0; s < N_SLICE; s++) begin : g_chk
            // R8: a slice that does not end its lane never carries a flag.
            p_flag_on_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) &&
                 ((s % psat_pkg::lane_span($past(lane_mode))) !=
                  (psat_pkg::lane_span($past(lane_mode)) - 1)) &&
                 (psat_pkg::lane_span($past(lane_mode)) <= N_SLICE))
                |-> !ovf_flags[s]);
            // R5: a signed add of operands with different signs has no flag.
            p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(signed_en) && !$past(sub_en) &&
                 ($past(op_a[s*SLICE_W + SLICE_W - 1]) != $past(op_b[s*SLICE_W + SLICE_W - 1])))
                |-> !ovf_flags[s]);
            // R10: a saturated unsigned add returns all ones in the top slice.
            p_usat_add_r10: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(sat_en) && !$past(signed_en) && !$past(sub_en) && ovf_flags[s])
                |-> (result[s*SLICE_W +: SLICE_W] == {SLICE_W{1'b1}}));
            // R10: a saturated unsigned subtract returns zero in the top slice.
            p_usat_sub_r10: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(sat_en) && !$past(signed_en) && $past(sub_en) && ovf_flags[s])
                |-> (result[s*SLICE_W +: SLICE_W] == '0));
            // R9: signed positive overflow puts 0111..1 in the top slice.
            p_ssat_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && $past(sat_en) && $past(signed_en) && ovf_flags[s] &&
                 !$past(op_a[s*SLICE_W + SLICE_W - 1]))
                |-> (result[s*SLICE_W +: SLICE_W] == {1'b0, {(SLICE_W-1){1'b1}}}));
        end
    end else begin : g_comb
        assign result    = res_c;
        assign ovf_flags = ovf;
    end
endmodule

// File: tb/psat_adder_bench.sv
module psat_adder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic [1:0]  lane_mode = '0;
    logic        sub_en = 1'b0, signed_en = 1'b0, sat_en = 1'b0;
    logic [63:0] result;
    logic [7:0]  ovf_flags;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    psat_adder u_psat_adder (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
        .lane_mode(lane_mode), .sub_en(sub_en), .signed_en(signed_en),
        .sat_en(sat_en), .result(result), .ovf_flags(ovf_flags)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Arithmetic reference built from the requirements, lane by lane.
    function automatic void model(input logic [63:0] a, input logic [63:0] b,
                                  input logic [1:0] m, input logic sub,
                                  input logic sgn, input logic sat,
                                  output logic [63:0] r, output logic [7:0] f);
        int w  = 8 << m;
        int nl = 64 / w;
        logic [64:0] mask = (65'd1 << w) - 65'd1;
        r = '0; f = '0;
        for (int l = 0; l < nl; l++) begin
            logic [64:0] la, lb, s, lr;
            logic as, bs, rs, ov;
            la = ({1'b0, a} >> (l*w)) & mask;
            lb = ({1'b0, b} >> (l*w)) & mask;
            s  = sub ? (la - lb) : (la + lb);
            as = la[w-1]; bs = lb[w-1]; rs = s[w-1];
            if (sgn) ov = sub ? (as != bs && rs != as) : (as == bs && rs != as);
            else     ov = sub ? (lb > la) : s[w];
            lr = s & mask;
            if (sat && ov) begin
                if (sgn) lr = as ? (65'd1 << (w-1)) : (mask >> 1);
                else     lr = sub ? 65'd0 : mask;
            end
            r = r | 64'(lr << (l*w));
            if (ov) f[(l+1)*(w/8)-1] = 1'b1;
        end
    endfunction

    // Lane-sized edge values: 0, 1, smax, smin, all ones, smin+1, smax-1.
    function automatic logic [63:0] edge_val(input int k, input logic [1:0] m);
        int w  = 8 << m;
        int nl = 64 / w;
        logic [64:0] mask = (65'd1 << w) - 65'd1;
        logic [63:0] v = '0;
        for (int l = 0; l < nl; l++) begin
            logic [64:0] e;
            case ((k + l) % 7)
                0: e = 65'd0;
                1: e = 65'd1;
                2: e = mask >> 1;
                3: e = 65'd1 << (w-1);
                4: e = mask;
                5: e = (65'd1 << (w-1)) + 65'd1;
                default: e = (mask >> 1) - 65'd1;
            endcase
            v = v | 64'(e << (l*w));
        end
        return v;
    endfunction

    function automatic logic [7:0] top_mask(input logic [1:0] m);
        logic [7:0] t = '0;
        int span = 1 << m;
        for (int i = 0; i < 8; i++) if ((i % span) == span - 1) t[i] = 1'b1;
        return t;
    endfunction

    // Drive on a falling edge, compare one falling edge later (one register).
    task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic [1:0] m,
                         input logic sub, input logic sgn, input logic sat,
                         input string rtag, input string ftag);
        logic [63:0] er;
        logic [7:0]  ef;
        @(negedge clk);
        op_a = a; op_b = b; lane_mode = m; sub_en = sub; signed_en = sgn; sat_en = sat;
        model(a, b, m, sub, sgn, sat, er, ef);
        @(negedge clk);
        n_checks++;
        if (result !== er) begin
            n_fail++;
            $display("FAIL %s result mode=%0d sub=%0d sgn=%0d sat=%0d a=%h b=%h actual=%h expected=%h",
                     rtag, m, sub, sgn, sat, a, b, result, er);
        end
        n_checks++;
        if (ovf_flags !== ef) begin
            n_fail++;
            $display("FAIL %s flags mode=%0d sub=%0d sgn=%0d a=%h b=%h actual=%h expected=%h",
                     ftag, m, sub, sgn, a, b, ovf_flags, ef);
        end
        n_checks++;
        if ((ovf_flags & ~top_mask(m)) !== 8'h00) begin   // R8 placement
            n_fail++;
            $display("FAIL R8 non-top flag mode=%0d actual=%h expected=00",
                     m, ovf_flags & ~top_mask(m));
        end
    endtask

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        string rt, ft;
        // R12: reset state.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        n_checks++;
        if (result !== 64'h0 || ovf_flags !== 8'h0) begin
            n_fail++;
            $display("FAIL R12 reset actual=%h/%h expected=0/0", result, ovf_flags);
        end
        @(negedge clk); rst_n = 1'b1;

        // R5: signed add of opposite-sign extremes never flags.
        apply(64'h7F7F_7F7F_7F7F_7F7F, 64'h8080_8080_8080_8080, 2'd0, 1'b0, 1'b1, 1'b1, "R5", "R5");
        // R11: wrap with flag reported (0x7F+0x01 per byte).
        apply(64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'd0, 1'b0, 1'b1, 1'b0, "R11", "R4");
        // R1: a byte carry must not reach the next lane in 8-bit mode.
        apply(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'd0, 1'b0, 1'b0, 1'b0, "R1", "R7");
        // R1: the same operands in 16-bit mode do carry within a lane.
        apply(64'h00FF_00FF_00FF_00FF, 64'h0001_0001_0001_0001, 2'd1, 1'b0, 1'b0, 1'b0, "R1", "R7");

        // Near-exhaustive sweep over every mode and control combination.
        for (int m = 0; m < 4; m++)
            for (int c = 0; c < 8; c++) begin
                logic sub = c[0], sgn = c[1], sat = c[2];
                if (sat) rt = sgn ? "R9" : "R10";
                else     rt = sub ? "R3" : "R2";
                if (sgn) ft = sub ? "R6" : "R4";
                else     ft = "R7";
                for (int i = 0; i < 7; i++)
                    for (int j = 0; j < 7; j++)
                        apply(edge_val(i, 2'(m)), edge_val(j, 2'(m)), 2'(m), sub, sgn, sat, rt, ft);
                for (int k = 0; k < 24; k++)
                    apply({$urandom, $urandom}, {$urandom, $urandom}, 2'(m), sub, sgn, sat, rt, ft);
            end

        // R12: reset after a nonzero result clears the register.
        apply(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd3, 1'b0, 1'b0, 1'b0, "R12", "R7");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        n_checks++;
        if (result !== 64'h0 || ovf_flags !== 8'h0) begin
            n_fail++;
            $display("FAIL R12 mid-run reset actual=%h/%h expected=0/0", result, ovf_flags);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule